// File: doc/BRIEF.md
# Strap-Addressed SMBus Slave Address Recogniser

This block is the address front end of an SMBus/I2C slave. It oversamples the SCL and SDA bus lines with the system clock and finds START and STOP conditions. After each START it shifts in the eight-bit address byte and compares the upper seven bits with its own device address. On a match it acknowledges by enabling the open-drain SDA pull-down during the ninth SCL clock, and it reports the read/write direction. Register traffic after the address phase is handled elsewhere.

The device address is taken from four strap pins at reset release and then held until the next reset. The address is the fixed base 0x18 plus the strap value. A test input, sampled at the same moment, can force the base address 0x18 whatever the straps say. A second input selects a power-up mode in which an external configuration-load phase runs first. In that mode the block ignores the bus until a "configuration done" strobe arrives. From then on it is a slave for good and uses the address captured at reset.

Top module: `smbus_strap_slave`

## Requirements
- R1: The strap pins, the override input and the mode input are sampled at the last clock edge of reset and held; later changes on them alter neither `slave_addr_o` nor which address byte is matched.
- R2: With the override inactive, the device address is 0x18 plus the 4-bit strap value (0x18 to 0x27). The matching write byte is that address shifted left by one bit.
- R3: After a START, eight SDA bits are taken on rising SCL edges, most significant first. When bits 7..1 equal the device address, `addr_match_o` is high for exactly one clock cycle.
- R4: Bit 0 of the address byte is the direction: 0 is a write and 1 is a read. `rw_bit_o` carries it in the cycle of the match pulse and holds it afterwards.
- R5: On a match, `sda_oe_o` rises after the falling SCL edge that ends the eighth bit. It stays high while SCL is high in the ninth clock and falls after the ninth falling SCL edge.
- R6: On a mismatch, no match pulse is given and `sda_oe_o` stays low until the next START.
- R7: If the override input is high at reset while the mode input is low (slave mode), the device address is 0x18 (write byte 0x30) regardless of the straps.
- R8: If the mode input is high at reset, the override is not applied and no address byte is matched until `cfg_done_i` has been high for one clock. After that, matching is enabled permanently with the strap address.
- R9: A repeated START in the middle of an address byte discards the bits received so far and restarts reception.
- R10: A STOP releases `sda_oe_o` and returns the block to idle. SCL clocks that follow without a new START produce no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad (wired-AND bus level) |
| strap_i | input | 4 | Address strap pins |
| test_ovr_i | input | 1 | Test override; high at reset in slave mode forces address 0x18 |
| master_mode_i | input | 1 | High at reset: wait for configuration load before acting as slave |
| cfg_done_i | input | 1 | One-cycle strobe marking the end of the configuration load |
| sda_oe_o | output | 1 | Open-drain enable; high pulls SDA low |
| addr_match_o | output | 1 | One-cycle pulse on an address match |
| rw_bit_o | output | 1 | Direction bit of the last matched byte (1 = read) |
| slave_addr_o | output | 7 | Currently held seven-bit device address |

## Verification
All sixteen strap values are swept. For each one the bench sends the matching write byte, the matching read byte and the byte of the neighbouring address. This separates a correct base-plus-offset address from an off-by-one or a wrong shift, and a direction bit taken from the wrong position from a correct one. Each acknowledge is sampled in the eighth and ninth clocks, which tells a well-timed pull-down from one asserted early or held too long. Further sequences cover changing straps after reset, the override in slave mode against the same input in the configuration-first mode, a repeated START in mid-byte, and clocking after a STOP with no START. Each of these gives a different result if the condition logic or the mode latch is wrong.

// File: rtl/smb_pkg.sv
// Package: shared types of the strap-addressed SMBus slave.
// Assumes: nothing beyond IEEE 1800-2017.
package smb_pkg;

    // Address-phase state of the byte receiver.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ADDR     = 3'd1,
        ST_ACK_WAIT = 3'd2,
        ST_ACK      = 3'd3,
        ST_HOLD     = 3'd4
    } smb_state_e;

endpackage

// File: rtl/smb_sync.sv
// Module: smb_sync
// Brings one asynchronous bus line into the clk domain through a chain of
// flip-flops. Assumes the idle bus level is high, so reset loads ones.
module smb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/smb_cond_detect.sv
// Module: smb_cond_detect
// Turns synchronised SCL/SDA levels into one-cycle events: START, STOP and
// the rising and falling edges of SCL. Assumes the inputs are synchronous.
module smb_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s_i,
    input  logic sda_s_i,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic sda_bit_o
);

    logic scl_prev_q;
    logic sda_prev_q;

    // Keep the previous sampled levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_s_i;
            sda_prev_q <= sda_s_i;
        end
    end

    // Decode the bus conditions from the current and previous levels.
    always_comb begin
        start_o    = scl_s_i && scl_prev_q && sda_prev_q && !sda_s_i;
        stop_o     = scl_s_i && scl_prev_q && !sda_prev_q && sda_s_i;
        scl_rise_o = scl_s_i && !scl_prev_q;
        scl_fall_o = !scl_s_i && scl_prev_q;
        sda_bit_o  = sda_s_i;
    end

endmodule

// File: rtl/smb_addr_latch.sv
// Module: smb_addr_latch
// Holds the device address and the slave-enable state. Straps, the test
// override and the mode input are loaded on every reset clock and frozen
// when reset is released. In the configuration-first mode, slave operation
// starts at the first cfg_done_i strobe and then stays on.
module smb_addr_latch #(
    parameter int          STRAP_W   = 4,
    parameter int          ADDR_W    = 7,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 7'h18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               test_ovr_i,
    input  logic               master_mode_i,
    input  logic               cfg_done_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic               slave_en_o
);

    logic [STRAP_W-1:0] strap_q;
    logic               ovr_q;
    logic               master_q;
    logic               done_q;

    // Track the configuration pins while in reset, hold them afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q  <= strap_i;
            ovr_q    <= test_ovr_i && !master_mode_i;
            master_q <= master_mode_i;
        end
    end

    // Remember that the configuration phase has ended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (cfg_done_i) begin
            done_q <= 1'b1;
        end
    end

    // Form the address and the enable from the held state.
    always_comb begin
        addr_o     = ovr_q ? BASE_ADDR : BASE_ADDR + ADDR_W'(strap_q);
        slave_en_o = !master_q || done_q;
    end

    // R1: the address never moves once reset is over.
    a_r1_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(addr_o));

    // R8: once slave operation is enabled it stays enabled.
    a_r8_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(slave_en_o)) |-> slave_en_o);

endmodule

// File: rtl/smb_addr_fsm.sv
// Module: smb_addr_fsm
// Receives the address byte after START, compares it with the device
// address and drives the acknowledge. Assumes one-cycle bus events from
// smb_cond_detect. Stays silent after a mismatch until the next START.
module smb_addr_fsm
    import smb_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              sda_bit_i,
    input  logic              slave_en_i,
    input  logic [ADDR_W-1:0] my_addr_i,
    output logic              sda_oe_o,
    output logic              addr_match_o,
    output logic              rw_bit_o
);

    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    smb_state_e        state_q;
    logic [ADDR_W-1:0] shift_q;
    logic [CNT_W-1:0]  bitcnt_q;

    // Sequence the address phase: shift, compare, acknowledge, hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            shift_q      <= '0;
            bitcnt_q     <= '0;
            sda_oe_o     <= 1'b0;
            addr_match_o <= 1'b0;
            rw_bit_o     <= 1'b0;
        end else begin
            addr_match_o <= 1'b0;
            if (stop_i) begin
                state_q  <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else if (start_i) begin
                sda_oe_o <= 1'b0;
                bitcnt_q <= '0;
                shift_q  <= '0;
                state_q  <= slave_en_i ? ST_ADDR : ST_IDLE;
            end else begin
                case (state_q)
                    ST_ADDR: begin
                        if (scl_rise_i) begin
                            if (bitcnt_q == LAST_BIT) begin
                                if (shift_q == my_addr_i) begin
                                    addr_match_o <= 1'b1;
                                    rw_bit_o     <= sda_bit_i;
                                    state_q      <= ST_ACK_WAIT;
                                end else begin
                                    state_q <= ST_HOLD;
                                end
                            end else begin
                                shift_q  <= {shift_q[ADDR_W-2:0], sda_bit_i};
                                bitcnt_q <= bitcnt_q + 1'b1;
                            end
                        end
                    end
                    ST_ACK_WAIT: begin
                        if (scl_fall_i) begin
                            sda_oe_o <= 1'b1;
                            state_q  <= ST_ACK;
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall_i) begin
                            sda_oe_o <= 1'b0;
                            state_q  <= ST_HOLD;
                        end
                    end
                    default: begin
                        state_q <= state_q;
                    end
                endcase
            end
        end
    end

    // R3: a match is a single-cycle pulse.
    a_r3_match_single: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match_o |=> !addr_match_o);

    // R5: the pull-down only starts right after a falling SCL edge.
    a_r5_oe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> $past(scl_fall_i));

    // R5: the pull-down ends only at a falling SCL edge or a bus condition.
    a_r5_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe_o) |-> $past(scl_fall_i || stop_i || start_i));

    // R10: STOP always releases the line.
    a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !sda_oe_o);

endmodule

// File: rtl/smbus_strap_slave.sv
// Module: smbus_strap_slave
// Top of the strap-addressed SMBus slave address recogniser: synchronises
// the bus lines, detects bus conditions, holds the strapped address and
// acknowledges a matching address byte. Assumes a wired-AND SDA at the pad.
module smbus_strap_slave #(
    parameter int          STRAP_W     = 4,
    parameter int          ADDR_W      = 7,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 7'h18,
    parameter int          SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               test_ovr_i,
    input  logic               master_mode_i,
    input  logic               cfg_done_i,
    output logic               sda_oe_o,
    output logic               addr_match_o,
    output logic               rw_bit_o,
    output logic [ADDR_W-1:0]  slave_addr_o
);

    logic scl_s;
    logic sda_s;
    logic ev_start;
    logic ev_stop;
    logic ev_rise;
    logic ev_fall;
    logic sda_bit;
    logic slave_en;

    smb_sync #(.STAGES(SYNC_STAGES)) i_sync_scl (
        .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s)
    );

    smb_sync #(.STAGES(SYNC_STAGES)) i_sync_sda (
        .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s)
    );

    smb_cond_detect i_cond (
        .clk(clk), .rst_n(rst_n),
        .scl_s_i(scl_s), .sda_s_i(sda_s),
        .start_o(ev_start), .stop_o(ev_stop),
        .scl_rise_o(ev_rise), .scl_fall_o(ev_fall),
        .sda_bit_o(sda_bit)
    );

    smb_addr_latch #(
        .STRAP_W(STRAP_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
    ) i_latch (
        .clk(clk), .rst_n(rst_n),
        .strap_i(strap_i), .test_ovr_i(test_ovr_i),
        .master_mode_i(master_mode_i), .cfg_done_i(cfg_done_i),
        .addr_o(slave_addr_o), .slave_en_o(slave_en)
    );

    smb_addr_fsm #(.ADDR_W(ADDR_W)) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_i(ev_start), .stop_i(ev_stop),
        .scl_rise_i(ev_rise), .scl_fall_i(ev_fall),
        .sda_bit_i(sda_bit), .slave_en_i(slave_en),
        .my_addr_i(slave_addr_o),
        .sda_oe_o(sda_oe_o), .addr_match_o(addr_match_o),
        .rw_bit_o(rw_bit_o)
    );

    // R8: no match is reported while slave operation is still disabled.
    a_r8_silent_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        !slave_en |-> !addr_match_o);

endmodule

// File: tb/test_smbus_strap_slave.sv
module test_smbus_strap_slave;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [3:0] strap = 4'd0;
    logic       ovr = 1'b0;
    logic       mmode = 1'b0;
    logic       cfg_done = 1'b0;
    logic       sda_oe;
    logic       match;
    logic       rw;
    logic [6:0] saddr;
    logic       sda_bus;

    int checks = 0;
    int fails = 0;
    int match_cnt = 0;
    logic rw_seen = 1'b0;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    smbus_strap_slave i_smbus_strap_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .strap_i(strap), .test_ovr_i(ovr), .master_mode_i(mmode),
        .cfg_done_i(cfg_done), .sda_oe_o(sda_oe), .addr_match_o(match),
        .rw_bit_o(rw), .slave_addr_o(saddr)
    );

    always @(posedge clk) begin
        if (match) begin
            match_cnt = match_cnt + 1;
            rw_seen   = rw;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic waitq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic do_reset(input logic [3:0] s, input logic o, input logic m);
        rst_n = 1'b0; strap = s; ovr = o; mmode = m;
        scl_m = 1'b1; sda_m = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq(1);
        scl_m = 1'b1; waitq(1);
        sda_m = 1'b0; waitq(1);
        scl_m = 1'b0; waitq(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq(1);
        scl_m = 1'b1; waitq(1);
        sda_m = 1'b1; waitq(1);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; waitq(1);
            scl_m = 1'b1; waitq(2);
            scl_m = 1'b0; waitq(1);
        end
    endtask

    // Send a full address byte plus acknowledge clock and check the result.
    task automatic send_byte(input logic [7:0] b, input string tag,
                             input bit exp_match, input bit exp_rw);
        int  base;
        logic oe_bit8;
        logic oe_ack;
        base = match_cnt;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; waitq(1);
            scl_m = 1'b1; waitq(1);
            if (i == 0) oe_bit8 = sda_oe;
            waitq(1);
            scl_m = 1'b0; waitq(1);
        end
        sda_m = 1'b1; waitq(1);
        scl_m = 1'b1; waitq(1);
        oe_ack = sda_oe;
        waitq(1);
        scl_m = 1'b0; waitq(1);
        chk({tag, " R3 match count"}, match_cnt - base, exp_match ? 1 : 0);
        if (exp_match) chk({tag, " R4 rw bit"}, int'(rw_seen), int'(exp_rw));
        if (exp_match) chk({tag, " R4 rw held"}, int'(rw), int'(exp_rw));
        chk({tag, " R5 no drive in bit 8"}, int'(oe_bit8), 0);
        chk({tag, exp_match ? " R5 ack in clock 9" : " R6 silent in clock 9"},
            int'(oe_ack), exp_match ? 1 : 0);
        chk({tag, " R5 released after clock 9"}, int'(sda_oe), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // Reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 reset no match", int'(match), 0);
        chk("R5 reset no drive", int'(sda_oe), 0);

        // R2 R3 R4 R5 R6: full strap sweep
        for (int s = 0; s < 16; s++) begin
            logic [6:0] a;
            a = 7'h18 + 7'(s);
            do_reset(4'(s), 1'b0, 1'b0);
            chk("R2 address from strap", int'(saddr), int'(a));
            bus_start(); send_byte({a, 1'b0}, "R2 write", 1'b1, 1'b0); bus_stop();
            bus_start(); send_byte({a, 1'b1}, "R4 read", 1'b1, 1'b1); bus_stop();
            bus_start(); send_byte({a + 7'd1, 1'b0}, "R6 neighbour", 1'b0, 1'b0); bus_stop();
        end

        // R1: straps move after reset
        do_reset(4'd9, 1'b0, 1'b0);
        strap = 4'd2; ovr = 1'b1; mmode = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 address held", int'(saddr), 'h21);
        bus_start(); send_byte(8'h42, "R1 old address", 1'b1, 1'b0); bus_stop();
        bus_start(); send_byte(8'h34, "R1 new address", 1'b0, 1'b0); bus_stop();
        mmode = 1'b0; ovr = 1'b0;

        // R7: test override in slave mode
        do_reset(4'd5, 1'b1, 1'b0);
        chk("R7 override address", int'(saddr), 'h18);
        bus_start(); send_byte(8'h30, "R7 override byte", 1'b1, 1'b0); bus_stop();
        bus_start(); send_byte(8'h3a, "R7 strap byte", 1'b0, 1'b0); bus_stop();

        // R8: configuration-first mode, override not applied
        do_reset(4'd3, 1'b1, 1'b1);
        chk("R8 strap address kept", int'(saddr), 'h1b);
        bus_start(); send_byte(8'h36, "R8 before done", 1'b0, 1'b0); bus_stop();
        @(negedge clk); cfg_done = 1'b1; @(negedge clk); cfg_done = 1'b0;
        mmode = 1'b0;
        repeat (3) @(negedge clk);
        bus_start(); send_byte(8'h37, "R8 after done", 1'b1, 1'b1); bus_stop();
        bus_start(); send_byte(8'h36, "R8 stays slave", 1'b1, 1'b0); bus_stop();
        chk("R8 address after handover", int'(saddr), 'h1b);

        // R9: repeated START mid byte
        do_reset(4'd7, 1'b0, 1'b0);
        bus_start();
        send_bits(8'hff, 4);
        bus_start();
        send_byte(8'h3e, "R9 after restart", 1'b1, 1'b0);
        bus_stop();
        bus_start();
        send_bits(8'h3e, 3);
        bus_start();
        send_byte(8'h41, "R9 partial discarded", 1'b0, 1'b0);
        bus_stop();

        // R10: clocks after STOP without START
        bus_start();
        send_byte(8'h3f, "R10 matched first", 1'b1, 1'b1);
        bus_stop();
        chk("R10 released at stop", int'(sda_oe), 0);
        scl_m = 1'b0; waitq(1);
        send_byte(8'h3e, "R10 no start", 1'b0, 1'b0);
        bus_stop();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule